// File: doc/BRIEF.md
# Address Register Step Selector

This block keeps a small bank of address registers and works out how far the selected register moves during auto-increment and auto-decrement addressing. The step size comes from the access size. Long accesses move the register by four and word accesses move it by two. Byte accesses move it by one, except through the stack register, which moves by two so that the stack stays word-aligned.

For pre-decrement, the block presents the reduced value as the address of the access. For post-increment, it presents the current value as the access address and the advanced value as the pending update. A single-cycle commit strobe writes the pending value back into the selected register. A direct load port sets register contents. The memory access itself and all other effective-address modes belong elsewhere.

Top module: `addr_step_sel`

## Requirements
- R1: When `size_i` is 2'b10 or 2'b11 (long), `step_o` is 4.
- R2: When `size_i` is 2'b01 (word), `step_o` is 2.
- R3: When `size_i` is 2'b00 (byte) and `reg_i` is not 7, `step_o` is 1.
- R4: When `size_i` is 2'b00 (byte) and `reg_i` is 7 (the stack register), `step_o` is 2.
- R5: With `dec_i`=1 (pre-decrement), `next_o` equals `reg_o` minus `step_o`, and `ea_o` equals `next_o`.
- R6: With `dec_i`=0 (post-increment), `ea_o` equals `reg_o`, and `next_o` equals `reg_o` plus `step_o`.
- R7: Address arithmetic wraps modulo 2^32 in both directions.
- R8: A cycle with `stb_i`=1 and `wr_en_i`=0 writes `next_o` into the register selected by `reg_i`. The new value is visible on `reg_o` after that clock edge, and the other registers are unchanged.
- R9: With `stb_i`=0 and `wr_en_i`=0, no register changes.
- R10: `wr_en_i`=1 loads `wr_data_i` into the selected register and takes priority over `stb_i`.
- R11: After reset, every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| size_i | input | 2 | Access size: 00 byte, 01 word, 1x long |
| reg_i | input | 3 | Address register index |
| dec_i | input | 1 | 1 selects pre-decrement, 0 selects post-increment |
| stb_i | input | 1 | Commit the pending update |
| wr_en_i | input | 1 | Direct load enable |
| wr_data_i | input | 32 | Direct load value |
| step_o | output | 3 | Step amount |
| ea_o | output | 32 | Address used for the access |
| next_o | output | 32 | Register value after the update |
| reg_o | output | 32 | Current value of the selected register |

## Verification
The bench checks byte steps through register 7 against byte steps through register 6. A design that missed the stack exception would move the stack register by one and leave it misaligned. It also checks that a pre-decrement addresses the reduced value while a post-increment addresses the old one; swapping the two would shift every access by a step. The wrap tests start near zero and near the top of the address space, where a carry bug would show. The commit tests confirm that neighbouring registers keep their values and that a direct load overrides a simultaneous strobe.

// File: rtl/addr_step_sel.sv
module addr_step_sel #(
  parameter int AW     = 32,
  parameter int NREGS  = 8,
  parameter int SP_IDX = 7,
  localparam int SELW  = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      size_i,
  input  logic [SELW-1:0] reg_i,
  input  logic            dec_i,
  input  logic            stb_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_data_i,
  output logic [2:0]      step_o,
  output logic [AW-1:0]   ea_o,
  output logic [AW-1:0]   next_o,
  output logic [AW-1:0]   reg_o
);
  logic [AW-1:0] bank [NREGS];
  logic          is_sp;

  assign is_sp = (reg_i == SELW'(SP_IDX));
  assign reg_o = bank[reg_i];

  always_comb begin
    unique casez (size_i)
      2'b1?:   step_o = 3'd4;
      2'b01:   step_o = 3'd2;
      default: step_o = is_sp ? 3'd2 : 3'd1;
    endcase
  end

  assign next_o = dec_i ? reg_o - AW'(step_o) : reg_o + AW'(step_o);
  assign ea_o   = dec_i ? next_o : reg_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) bank[i] <= '0;
    end else if (wr_en_i) begin
      bank[reg_i] <= wr_data_i;
    end else if (stb_i) begin
      bank[reg_i] <= next_o;
    end
  end
endmodule

module addr_step_sel_chk #(
  parameter int AW   = 32,
  parameter int SELW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      size_i,
  input logic [SELW-1:0] reg_i,
  input logic            dec_i,
  input logic            stb_i,
  input logic            wr_en_i,
  input logic [AW-1:0]   wr_data_i,
  input logic [2:0]      step_o,
  input logic [AW-1:0]   ea_o,
  input logic [AW-1:0]   next_o,
  input logic [AW-1:0]   reg_o
);
  AST_LONG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    size_i[1] |-> step_o == 3'd4); // R1
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    size_i == 2'b01 |-> step_o == 3'd2); // R2
  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (size_i == 2'b00 && reg_i != 3'd7) |-> step_o == 3'd1); // R3
  AST_SP_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (size_i == 2'b00 && reg_i == 3'd7) |-> step_o == 3'd2); // R4
  AST_PREDEC_EA: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (ea_o == next_o && next_o + AW'(step_o) == reg_o)); // R5
  AST_POSTINC_EA: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_i |-> (ea_o == reg_o && next_o - AW'(step_o) == reg_o)); // R6
  AST_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && !wr_en_i) |=> (reg_i != $past(reg_i) || reg_o == $past(next_o))); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_i && !wr_en_i) |=> (reg_i != $past(reg_i) || $stable(reg_o))); // R9
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (reg_i != $past(reg_i) || reg_o == $past(wr_data_i))); // R10
endmodule

bind addr_step_sel addr_step_sel_chk #(.AW(AW), .SELW(SELW)) chk_i (.*);

// File: tb/addr_step_sel_tb.sv
module addr_step_sel_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  size_i = 0;
  logic [2:0]  reg_i = 0;
  logic        dec_i = 0, stb_i = 0, wr_en_i = 0;
  logic [31:0] wr_data_i = 0;
  logic [2:0]  step_o;
  logic [31:0] ea_o, next_o, reg_o;
  int vecs = 0, errs = 0;

  always #5 clk = ~clk;

  addr_step_sel dut_i (.clk(clk), .rst_n(rst_n), .size_i(size_i), .reg_i(reg_i),
    .dec_i(dec_i), .stb_i(stb_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .step_o(step_o), .ea_o(ea_o), .next_o(next_o), .reg_o(reg_o));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setup(logic [1:0] sz, logic [2:0] r, logic d);
    @(negedge clk); size_i = sz; reg_i = r; dec_i = d; #1;
  endtask

  task automatic load(logic [2:0] r, logic [31:0] v);
    @(negedge clk); reg_i = r; wr_data_i = v; wr_en_i = 1;
    @(negedge clk); wr_en_i = 0;
  endtask

  task automatic t_reset();
    for (int r = 0; r < 8; r++) begin
      setup(2'b01, 3'(r), 0); chk("R11 reset value", reg_o, 0);
    end
  endtask

  task automatic t_steps();
    setup(2'b10, 3'd0, 0); chk("R1 long step", 32'(step_o), 4);
    setup(2'b11, 3'd7, 1); chk("R1 long step size 11", 32'(step_o), 4);
    setup(2'b01, 3'd7, 0); chk("R2 word step", 32'(step_o), 2);
    setup(2'b00, 3'd6, 0); chk("R3 byte step r6", 32'(step_o), 1);
    setup(2'b00, 3'd0, 1); chk("R3 byte step r0", 32'(step_o), 1);
    setup(2'b00, 3'd7, 0); chk("R4 byte step sp", 32'(step_o), 2);
    setup(2'b00, 3'd7, 1); chk("R4 byte step sp dec", 32'(step_o), 2);
  endtask

  task automatic t_predec();
    load(3'd1, 32'h1000);
    setup(2'b10, 3'd1, 1);
    chk("R5 predec next", next_o, 32'h0FFC); chk("R5 predec ea", ea_o, 32'h0FFC);
    load(3'd7, 32'h2000);
    setup(2'b00, 3'd7, 1);
    chk("R5 sp byte predec ea", ea_o, 32'h1FFE);
  endtask

  task automatic t_postinc();
    setup(2'b01, 3'd1, 0);
    chk("R6 postinc ea", ea_o, 32'h1000); chk("R6 postinc next", next_o, 32'h1002);
  endtask

  task automatic t_wrap();
    setup(2'b00, 3'd2, 1); chk("R7 wrap down", next_o, 32'hFFFF_FFFF);
    load(3'd3, 32'hFFFF_FFFE);
    setup(2'b10, 3'd3, 0); chk("R7 wrap up", next_o, 32'h0000_0002);
  endtask

  task automatic t_commit();
    load(3'd4, 32'h100); load(3'd5, 32'h500);
    setup(2'b00, 3'd4, 0); stb_i = 1;
    @(negedge clk); stb_i = 0; #1;
    chk("R8 commit postinc", reg_o, 32'h101);
    setup(2'b01, 3'd4, 1); stb_i = 1;
    @(negedge clk); stb_i = 0; #1;
    chk("R8 commit predec", reg_o, 32'hFF);
    setup(2'b01, 3'd5, 0); chk("R8 neighbour untouched", reg_o, 32'h500);
  endtask

  task automatic t_hold();
    setup(2'b10, 3'd5, 1);
    repeat (3) @(negedge clk); #1;
    chk("R9 hold without strobe", reg_o, 32'h500);
  endtask

  task automatic t_load();
    @(negedge clk); reg_i = 3'd6; wr_data_i = 32'hCAFE_0000; wr_en_i = 1; stb_i = 1;
    @(negedge clk); wr_en_i = 0; stb_i = 0; #1;
    chk("R10 load over strobe", reg_o, 32'hCAFE_0000);
  endtask

  initial begin
    #2000000;
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_steps(); t_predec(); t_postinc(); t_wrap();
    t_commit(); t_hold(); t_load();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule